// File: doc/BRIEF.md
# Transactional Memory Conflict Tracker

This block sits next to a small first-level cache and keeps the bookkeeping for hardware transactional memory. The core issues commands to open, commit or abort a transaction. While a transaction is open, core loads and stores mark their cache line in a per-line read set or write set. Stores inside a transaction are buffered in place and tracked with a speculative bit. Snoops from the coherence fabric are checked against both sets to detect conflicts.

When a conflict is detected the transaction fails. From then on, every core access is turned into a no-op, and its response carries a failure flag so the core can raise its abort path. A failure-reason code is held for the core to read. Abort throws away the speculative lines and clears all tracking state. Commit turns the speculative lines into ordinary modified lines.

The line index is taken directly from the low address bits. Line state is modelled only as a valid bit, a dirty bit and a speculative bit per line. Data arrays, register checkpoints and the full coherence protocol live outside this block.

Top module: `htm_tracker`

## Requirements
- R1: After synchronous active-low reset, the block is outside a transaction, with no failure and reason code 0. All valid, dirty, speculative, read-set and write-set bits are 0, and cmd_ack, cmd_err, rsp_valid and rsp_fail are 0.
- R2: Command codes are 1 = begin, 2 = commit, 3 = abort. A begin outside a transaction enters transactional state on the next edge. Each command is answered one cycle later on cmd_ack. cmd_err is also raised, with no state change, for code 0, for a begin inside a transaction, and for a commit or abort outside one.
- R3: The line index is acc_addr[IDX_W-1:0]. Any accepted access sets that line's valid bit. Inside a transaction, a load sets the read-set bit and a store sets both the write-set bit and the speculative bit. Outside a transaction, a store sets the dirty bit and neither set changes.
- R4: An invalidation snoop (snp_inval = 1) clears the valid, dirty and speculative bits of its line. While in a transaction, an invalidation that hits the read set or the write set fails the transaction.
- R5: A remote-read snoop (snp_inval = 0) fails an open transaction only if its line is in the write set. A remote read of a line that is only in the read set has no effect.
- R6: Every access is answered with rsp_valid one cycle later. While a transaction has failed, an access changes no line bit and no set bit, and its response has rsp_fail = 1. rsp_fail is 0 in every other case.
- R7: Abort inside a transaction leaves transactional state. It clears the failure flag, the reason code and both sets. Every speculative line loses its valid, dirty and speculative bits.
- R8: A successful commit leaves transactional state and clears both sets. Every speculative line gets its dirty bit set and its speculative bit cleared, and stays valid.
- R9: The reason code is latched only on the first failure and is kept until abort. The codes are 1 = invalidation hit on the read set, 2 = invalidation hit on the write set, 3 = remote read of the write set. An invalidation that hits both sets reports 2.
- R10: A commit while the transaction has failed is answered with cmd_err. The block stays in a failed transaction.
- R11: A snoop and a core access in the same cycle are evaluated snoop first. If the snoop fails the transaction, the access is already a no-op and is answered with rsp_fail = 1. A commit in the same cycle as a conflicting snoop is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Core transaction command present |
| cmd_op | input | 2 | Command code: 1 begin, 2 commit, 3 abort |
| acc_valid | input | 1 | Core load or store present |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Core access address |
| snp_valid | input | 1 | Snoop from the fabric present |
| snp_inval | input | 1 | 1 = invalidation, 0 = remote read |
| snp_addr | input | ADDR_W | Snoop address |
| cmd_ack | output | 1 | Command answered (one cycle after cmd_valid) |
| cmd_err | output | 1 | Command rejected |
| rsp_valid | output | 1 | Access answered (one cycle after acc_valid) |
| rsp_fail | output | 1 | Access was a no-op in a failed transaction |
| in_txn | output | 1 | Transactional state |
| failed | output | 1 | Transaction has failed |
| fail_rsn | output | 2 | Latched failure reason |
| line_valid | output | NUM_LINES | Per-line valid bits |
| line_dirty | output | NUM_LINES | Per-line dirty bits |
| line_spec | output | NUM_LINES | Per-line speculative-write bits |
| rd_set | output | NUM_LINES | Transactional read set |
| wr_set | output | NUM_LINES | Transactional write set |

## Verification
A lost or stray set bit does not show up when it is written. It shows up at the first snoop to that line, as a missing or false failure one edge after the snoop, and later as a wrong valid or dirty bit after commit or abort. Because of this, the stimulus keeps the line index space small, so snoops often land on lines that were already touched. A reason code overwritten by a later conflict shows on fail_rsn one edge after the second conflict. A no-op access that leaks shows at once on the line bits, or as rsp_fail being 0 one cycle after the access.

// File: rtl/htm_pkg.sv
// Shared encodings for the transactional memory conflict tracker.
// Assumes: command and reason codes are 2 bits wide and are decoded by the core.
package htm_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_BEGIN  = 2'd1,
        OP_COMMIT = 2'd2,
        OP_ABORT  = 2'd3
    } htm_op_e;

    typedef enum logic [1:0] {
        RSN_NONE   = 2'd0,
        RSN_INV_RD = 2'd1,
        RSN_INV_WR = 2'd2,
        RSN_RD_WR  = 2'd3
    } htm_rsn_e;
endpackage

// File: rtl/htm_conflict_detect.sv
// Combinational snoop-versus-set comparison.
// Reports whether the current snoop conflicts with the open transaction and
// which reason applies. The write-set invalidation hit has the highest priority.
// Assumes: the sets passed in are the registered (pre-edge) values.
module htm_conflict_detect
    import htm_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 in_txn,
    input  logic                 snp_valid,
    input  logic                 snp_inval,
    input  logic [IDX_W-1:0]     snp_idx,
    input  logic [NUM_LINES-1:0] rd_set,
    input  logic [NUM_LINES-1:0] wr_set,
    output logic                 conflict,
    output logic [1:0]           conflict_rsn
);
    logic hit_inv_wr, hit_inv_rd, hit_rd_wr;

    // Classify the snoop against the read and write sets.
    always_comb begin
        hit_inv_wr = snp_valid &  snp_inval & wr_set[snp_idx];
        hit_inv_rd = snp_valid &  snp_inval & rd_set[snp_idx];
        hit_rd_wr  = snp_valid & ~snp_inval & wr_set[snp_idx];
    end

    // Pick the reason by priority and gate with transactional state.
    always_comb begin
        conflict = in_txn & (hit_inv_wr | hit_inv_rd | hit_rd_wr);
        if (hit_inv_wr)      conflict_rsn = RSN_INV_WR;
        else if (hit_inv_rd) conflict_rsn = RSN_INV_RD;
        else if (hit_rd_wr)  conflict_rsn = RSN_RD_WR;
        else                 conflict_rsn = RSN_NONE;
    end
endmodule

// File: rtl/htm_txn_ctrl.sv
// Transaction state machine.
// Tracks transactional and failed state and latches the first failure reason.
// Decides whether each command is accepted and answers commands and accesses
// one cycle later.
// Assumes: the conflict input already includes same-cycle snoops (snoop first).
module htm_txn_ctrl
    import htm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       acc_valid,
    input  logic       conflict,
    input  logic [1:0] conflict_rsn,
    output logic       in_txn,
    output logic       failed,
    output logic [1:0] fail_rsn,
    output logic       cmd_ack,
    output logic       cmd_err,
    output logic       rsp_valid,
    output logic       rsp_fail,
    output logic       acc_en,
    output logic       commit_go,
    output logic       abort_go
);
    logic fail_eff, begin_go, cmd_bad;

    // Decode accepted commands and the access gate.
    always_comb begin
        fail_eff  = failed | conflict;
        begin_go  = cmd_valid && (cmd_op == OP_BEGIN)  && !in_txn;
        commit_go = cmd_valid && (cmd_op == OP_COMMIT) && in_txn && !fail_eff;
        abort_go  = cmd_valid && (cmd_op == OP_ABORT)  && in_txn;
        cmd_bad   = cmd_valid && !(begin_go || commit_go || abort_go);
        acc_en    = acc_valid && !(in_txn && fail_eff);
    end

    // Transactional state, failure flag and first-failure reason.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_txn   <= 1'b0;
            failed   <= 1'b0;
            fail_rsn <= RSN_NONE;
        end else begin
            if (begin_go)
                in_txn <= 1'b1;
            else if (commit_go || abort_go)
                in_txn <= 1'b0;

            if (abort_go) begin
                failed   <= 1'b0;
                fail_rsn <= RSN_NONE;
            end else if (conflict) begin
                failed <= 1'b1;
                if (!failed)
                    fail_rsn <= conflict_rsn;
            end
        end
    end

    // One-cycle responses to commands and accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_ack   <= 1'b0;
            cmd_err   <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_fail  <= 1'b0;
        end else begin
            cmd_ack   <= cmd_valid;
            cmd_err   <= cmd_bad;
            rsp_valid <= acc_valid;
            rsp_fail  <= acc_valid && in_txn && fail_eff;
        end
    end

    // R9: reason stays latched while failed until abort
    a_r9_reason_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (failed && !(cmd_valid && cmd_op == OP_ABORT)) |=> (failed && $stable(fail_rsn)));

    // R10: commit in failed state is refused and the state is kept
    a_r10_commit_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_COMMIT && failed) |=> (cmd_err && in_txn && failed));

    // R7: abort leaves transactional state with no failure
    a_r7_abort_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ABORT && in_txn) |=> (!in_txn && !failed && fail_rsn == RSN_NONE));

    // R6: failure exists only inside a transaction
    a_r6_fail_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> in_txn);

    // R6: a failed response is always an access response
    a_r6_rsp_fail_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fail |-> rsp_valid);
endmodule

// File: rtl/htm_line_array.sv
// Per-line state and transactional read and write sets.
// Updates apply in order: snoop invalidation, then the core access, then the
// commit or abort transform.
// Assumes: acc_en is already clear for accesses in a failed transaction.
module htm_line_array #(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_en,
    input  logic                 acc_write,
    input  logic [IDX_W-1:0]     acc_idx,
    input  logic                 txn_mode,
    input  logic                 snp_inv,
    input  logic [IDX_W-1:0]     snp_idx,
    input  logic                 commit_go,
    input  logic                 abort_go,
    output logic [NUM_LINES-1:0] valid,
    output logic [NUM_LINES-1:0] dirty,
    output logic [NUM_LINES-1:0] spec,
    output logic [NUM_LINES-1:0] rd_set,
    output logic [NUM_LINES-1:0] wr_set
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic nv, nd, ns, nr, nw;

        // Next state of line i, with the update steps applied in order.
        always_comb begin
            nv = valid[i]; nd = dirty[i]; ns = spec[i];
            nr = rd_set[i]; nw = wr_set[i];
            if (snp_inv && snp_idx == IDX_W'(i)) begin
                nv = 1'b0; nd = 1'b0; ns = 1'b0;
            end
            if (acc_en && acc_idx == IDX_W'(i)) begin
                nv = 1'b1;
                if (txn_mode) begin
                    if (acc_write) begin nw = 1'b1; ns = 1'b1; end
                    else           nr = 1'b1;
                end else if (acc_write) begin
                    nd = 1'b1;
                end
            end
            if (abort_go) begin
                if (ns) begin nv = 1'b0; nd = 1'b0; end
                ns = 1'b0; nr = 1'b0; nw = 1'b0;
            end else if (commit_go) begin
                if (ns) nd = 1'b1;
                ns = 1'b0; nr = 1'b0; nw = 1'b0;
            end
        end

        // Register line i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[i] <= 1'b0; dirty[i] <= 1'b0; spec[i] <= 1'b0;
                rd_set[i] <= 1'b0; wr_set[i] <= 1'b0;
            end else begin
                valid[i] <= nv; dirty[i] <= nd; spec[i] <= ns;
                rd_set[i] <= nr; wr_set[i] <= nw;
            end
        end
    end

    // R3: a speculative line is always in the write set
    a_r3_spec_in_wrset: assert property (@(posedge clk) disable iff (!rst_n)
        (spec & ~wr_set) == '0);

    // R8: commit leaves no speculative line and empty sets
    a_r8_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |=> (spec == '0 && rd_set == '0 && wr_set == '0));

    // R6: with no accepted access and no commit or abort, the sets hold
    a_r6_sets_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !commit_go && !abort_go) |=> ($stable(rd_set) && $stable(wr_set)));
endmodule

// File: rtl/htm_tracker.sv
// Top level of the transactional memory conflict tracker.
// Connects the snoop comparator, the transaction controller and the line array.
// Assumes: ADDR_W >= log2(NUM_LINES); the line index is the low address bits.
module htm_tracker
    import htm_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 12,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic                 snp_valid,
    input  logic                 snp_inval,
    input  logic [ADDR_W-1:0]    snp_addr,
    output logic                 cmd_ack,
    output logic                 cmd_err,
    output logic                 rsp_valid,
    output logic                 rsp_fail,
    output logic                 in_txn,
    output logic                 failed,
    output logic [1:0]           fail_rsn,
    output logic [NUM_LINES-1:0] line_valid,
    output logic [NUM_LINES-1:0] line_dirty,
    output logic [NUM_LINES-1:0] line_spec,
    output logic [NUM_LINES-1:0] rd_set,
    output logic [NUM_LINES-1:0] wr_set
);
    logic [IDX_W-1:0] acc_idx, snp_idx;
    logic             conflict, acc_en, commit_go, abort_go, snp_inv;
    logic [1:0]       conflict_rsn;

    // Line indices come directly from the low address bits.
    always_comb begin
        acc_idx = acc_addr[IDX_W-1:0];
        snp_idx = snp_addr[IDX_W-1:0];
        snp_inv = snp_valid & snp_inval;
    end

    htm_conflict_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .in_txn(in_txn), .snp_valid(snp_valid), .snp_inval(snp_inval),
        .snp_idx(snp_idx), .rd_set(rd_set), .wr_set(wr_set),
        .conflict(conflict), .conflict_rsn(conflict_rsn)
    );

    htm_txn_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .acc_valid(acc_valid), .conflict(conflict), .conflict_rsn(conflict_rsn),
        .in_txn(in_txn), .failed(failed), .fail_rsn(fail_rsn),
        .cmd_ack(cmd_ack), .cmd_err(cmd_err), .rsp_valid(rsp_valid),
        .rsp_fail(rsp_fail), .acc_en(acc_en), .commit_go(commit_go),
        .abort_go(abort_go)
    );

    htm_line_array #(.NUM_LINES(NUM_LINES)) u_lines (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_write(acc_write),
        .acc_idx(acc_idx), .txn_mode(in_txn), .snp_inv(snp_inv),
        .snp_idx(snp_idx), .commit_go(commit_go), .abort_go(abort_go),
        .valid(line_valid), .dirty(line_dirty), .spec(line_spec),
        .rd_set(rd_set), .wr_set(wr_set)
    );
endmodule

// File: tb/htm_tracker_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases followed by seeded random traffic,
// compared every cycle against a reference model written from the requirements.
module htm_tracker_tb_top;
    localparam int N  = 16;
    localparam int AW = 12;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, acc_valid = 1'b0, acc_write = 1'b0;
    logic snp_valid = 1'b0, snp_inval = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [AW-1:0] acc_addr = '0, snp_addr = '0;
    logic cmd_ack, cmd_err, rsp_valid, rsp_fail, in_txn, failed;
    logic [1:0] fail_rsn;
    logic [N-1:0] line_valid, line_dirty, line_spec, rd_set, wr_set;

    always #2.5 clk = ~clk;

    htm_tracker #(.NUM_LINES(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .snp_valid(snp_valid), .snp_inval(snp_inval), .snp_addr(snp_addr),
        .cmd_ack(cmd_ack), .cmd_err(cmd_err), .rsp_valid(rsp_valid),
        .rsp_fail(rsp_fail), .in_txn(in_txn), .failed(failed),
        .fail_rsn(fail_rsn), .line_valid(line_valid), .line_dirty(line_dirty),
        .line_spec(line_spec), .rd_set(rd_set), .wr_set(wr_set)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Reference model state
    logic m_in, m_fail, m_ack, m_err, m_rv, m_rf;
    logic [1:0] m_rsn;
    logic [N-1:0] m_v, m_d, m_s, m_r, m_w;

    task automatic model_reset();
        m_in = 0; m_fail = 0; m_rsn = 0; m_ack = 0; m_err = 0; m_rv = 0; m_rf = 0;
        m_v = '0; m_d = '0; m_s = '0; m_r = '0; m_w = '0;
    endtask

    // Next model state from the currently driven inputs (called before the edge).
    task automatic model_step();
        logic [IW-1:0] si, ai;
        logic cw, cr, crw, conf, feff, bg, cg, ag, acc_ok;
        logic [1:0] rn;
        si = snp_addr[IW-1:0];
        ai = acc_addr[IW-1:0];
        cw   = snp_valid &  snp_inval & m_w[si];
        cr   = snp_valid &  snp_inval & m_r[si];
        crw  = snp_valid & ~snp_inval & m_w[si];
        conf = m_in & (cw | cr | crw);
        rn   = cw ? 2'd2 : (cr ? 2'd1 : 2'd3);
        feff = m_fail | conf;
        bg = cmd_valid && cmd_op == 2'd1 && !m_in;
        cg = cmd_valid && cmd_op == 2'd2 && m_in && !feff;
        ag = cmd_valid && cmd_op == 2'd3 && m_in;
        acc_ok = acc_valid && !(m_in && feff);
        m_ack = cmd_valid;
        m_err = cmd_valid && !(bg || cg || ag);
        m_rv  = acc_valid;
        m_rf  = acc_valid && m_in && feff;
        if (snp_valid && snp_inval) begin
            m_v[si] = 0; m_d[si] = 0; m_s[si] = 0;
        end
        if (acc_ok) begin
            m_v[ai] = 1;
            if (m_in) begin
                if (acc_write) begin m_w[ai] = 1; m_s[ai] = 1; end
                else m_r[ai] = 1;
            end else if (acc_write) m_d[ai] = 1;
        end
        if (ag) begin
            m_v = m_v & ~m_s; m_d = m_d & ~m_s;
            m_s = '0; m_r = '0; m_w = '0;
            m_fail = 0; m_rsn = 0;
        end else begin
            if (cg) begin
                m_d = m_d | m_s; m_s = '0; m_r = '0; m_w = '0;
            end
            if (conf) begin
                if (!m_fail) m_rsn = rn;
                m_fail = 1;
            end
        end
        if (bg) m_in = 1;
        else if (cg || ag) m_in = 0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 in_txn",         32'(in_txn),     32'(m_in));
        chk("R2 cmd_ack",        32'(cmd_ack),    32'(m_ack));
        chk("R2/R10 cmd_err",    32'(cmd_err),    32'(m_err));
        chk("R4/R5 failed",      32'(failed),     32'(m_fail));
        chk("R9 fail_rsn",       32'(fail_rsn),   32'(m_rsn));
        chk("R6 rsp_valid",      32'(rsp_valid),  32'(m_rv));
        chk("R6/R11 rsp_fail",   32'(rsp_fail),   32'(m_rf));
        chk("R3/R7 line_valid",  32'(line_valid), 32'(m_v));
        chk("R3/R8 line_dirty",  32'(line_dirty), 32'(m_d));
        chk("R3/R8 line_spec",   32'(line_spec),  32'(m_s));
        chk("R3 rd_set",         32'(rd_set),     32'(m_r));
        chk("R3 wr_set",         32'(wr_set),     32'(m_w));
    endtask

    // Drive one cycle of stimulus at a falling edge, then compare after the next one.
    task automatic step(input logic cv, input logic [1:0] op,
                        input logic av, input logic aw, input logic [AW-1:0] aa,
                        input logic sv, input logic sn, input logic [AW-1:0] sa);
        cmd_valid = cv; cmd_op = op; acc_valid = av; acc_write = aw; acc_addr = aa;
        snp_valid = sv; snp_inval = sn; snp_addr = sa;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        step(0, 0, 0, 0, '0, 0, 0, '0);
    endtask
    task automatic cmd(input logic [1:0] op);
        step(1, op, 0, 0, '0, 0, 0, '0);
    endtask
    task automatic acc(input logic w, input logic [AW-1:0] a);
        step(0, 0, 1, w, a, 0, 0, '0);
    endtask
    task automatic snp(input logic inv, input logic [AW-1:0] a);
        step(0, 0, 0, 0, '0, 1, inv, a);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h1F2E_3D4C;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        compare_all();
        chk("R1 line_valid after reset", 32'(line_valid), 0);
        chk("R1 in_txn after reset", 32'(in_txn), 0);

        // R2: commit and abort outside a transaction are errors
        cmd(2'd2); chk("R2 commit outside err", 32'(cmd_err), 1);
        cmd(2'd3); chk("R2 abort outside err", 32'(cmd_err), 1);
        cmd(2'd1); chk("R2 begin enters", 32'(in_txn), 1);
        cmd(2'd1); chk("R2 nested begin err", 32'(cmd_err), 1);
        // R3: load index 3 (upper bits ignored), store index 5
        acc(0, 12'h013); chk("R3 load rd bit", 32'(rd_set[3]), 1);
        acc(1, 12'h105); chk("R3 store spec bit", 32'(line_spec[5]), 1);
        // R5: remote read of a read-only line is harmless, of a written line fails
        snp(0, 12'h003); chk("R5 remote read of rd set", 32'(failed), 0);
        snp(0, 12'h0A5); chk("R5 remote read of wr set", 32'(failed), 1);
        chk("R9 reason remote read", 32'(fail_rsn), 3);
        // R9: later conflict keeps first reason
        snp(1, 12'h003); chk("R9 reason kept", 32'(fail_rsn), 3);
        // R6: access after failure is a no-op with failed response
        acc(1, 12'h009); chk("R6 rsp_fail", 32'(rsp_fail), 1);
        chk("R6 no set change", 32'(wr_set[9]), 0);
        // R10: commit while failed is refused
        cmd(2'd2); chk("R10 commit refused", 32'(cmd_err), 1);
        chk("R10 still in txn", 32'(in_txn), 1);
        // R7: abort invalidates the speculative line
        cmd(2'd3); chk("R7 spec line invalid", 32'(line_valid[5]), 0);
        chk("R7 failed cleared", 32'(failed), 0);

        // R8: plain store, then transactional stores and commit
        acc(1, 12'h002); chk("R3 plain store dirty", 32'(line_dirty[2]), 1);
        cmd(2'd1);
        acc(1, 12'h007);
        acc(1, 12'h002);
        cmd(2'd2); chk("R8 commit dirty", 32'(line_dirty[7]), 1);
        chk("R8 commit valid", 32'(line_valid[7]), 1);
        chk("R8 spec cleared", 32'(line_spec), 0);

        // R11: snoop and access in the same cycle, snoop first
        cmd(2'd1);
        acc(0, 12'h004);
        step(0, 0, 1, 0, 12'h006, 1, 1, 12'h004);
        chk("R11 same-cycle rsp_fail", 32'(rsp_fail), 1);
        chk("R11 no rd bit for no-op", 32'(rd_set[6]), 0);
        chk("R4 reason inval read", 32'(fail_rsn), 1);
        chk("R4 snooped line invalid", 32'(line_valid[4]), 0);
        cmd(2'd3);

        // R9: invalidation hitting both sets reports write-set reason
        cmd(2'd1);
        acc(1, 12'h001);
        acc(0, 12'h001);
        snp(1, 12'h001); chk("R9 both sets -> 2", 32'(fail_rsn), 2);
        chk("R4 inval clears spec", 32'(line_spec[1]), 0);
        cmd(2'd3);

        // R11: commit with a same-cycle conflicting snoop is refused
        cmd(2'd1);
        acc(1, 12'h00B);
        step(1, 2'd2, 0, 0, '0, 1, 0, 12'h00B);
        chk("R11 commit refused on conflict", 32'(cmd_err), 1);
        cmd(2'd3);
        idle();

        // Random traffic over a small index range to force collisions
        for (int k = 0; k < 6000; k++) begin
            logic cv, av, sv;
            logic [1:0] op;
            cv = ($urandom_range(0, 99) < 8);
            op = 2'($urandom_range(0, 3));
            if (op == 2'd2 && $urandom_range(0, 1) == 0) op = 2'd3;
            av = ($urandom_range(0, 99) < 55);
            sv = ($urandom_range(0, 99) < 20);
            step(cv, op, av, 1'($urandom),
                 {AW'($urandom) & ~AW'(N - 1)} | AW'($urandom_range(0, 5)),
                 sv, 1'($urandom),
                 {AW'($urandom) & ~AW'(N - 1)} | AW'($urandom_range(0, 5)));
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule